// File: doc/BRIEF.md
# Receiver Lock Qualification Sequencer

This block decides when the data coming out of a serial receiver's clock-data-recovery stage can be trusted. It keeps the receive-side digital logic in reset until the raw lock flag has stayed high, without a break, for a qualification time set at run time in clock cycles. Only then does it release the reset. One cycle later it raises a link-valid flag for the protocol logic downstream. A single lock pulse is never enough. The qualification time must be set longer than the regular spurious toggling that the lock flag shows when no transmitter is driving the line. As a guide, 125000 cycles gives 500 µs at 250 MHz.

An optional gate holds the block in a waiting state until a signal-detect flag reports energy on the line. While it waits, lock is not looked at. Both flags are asynchronous to the block clock and pass through two-flop synchronizers. If lock is lost, or signal detect is lost while gating is enabled, the block drops link-valid at once, asserts reset again and restarts qualification.

Top module: `rx_lock_qualifier`

## Requirements
- R1: While `rst_ni` is low, and on its release, `rx_digital_reset_o` is 1, `link_valid_o` is 0 and `state_o` is 2'b00.
- R2: `state_o` encodes the phase as 2'b00 reset hold, 2'b01 waiting for signal, 2'b10 qualifying and 2'b11 link up.
- R3: `lock_i` and `sigdet_i` are each resynchronized through two flops before any decision uses them.
- R4: With gating off, and the block qualifying, `lock_i` may go high before clock edge 1 and stay high. `rx_digital_reset_o` then first reads 0 after edge Q+2, where Q is `qual_cycles_i`. A value of 0 is treated as 1.
- R5: Any low cycle of the synchronized lock during qualification clears the count. Release then needs Q+2 edges counted from the edge after lock returns.
- R6: A lock pulse of Q-1 cycles never releases reset. A pulse of exactly Q cycles releases it for exactly one cycle and never raises `link_valid_o`.
- R7: `link_valid_o` first reads 1 one edge after `rx_digital_reset_o` first reads 0. It is never 1 while the reset output is 1.
- R8: With `gate_en_i` = 1 and `sigdet_i` = 0, the block stays in state 2'b01 with reset asserted, whatever `lock_i` does.
- R9: With gating on and lock already high, `sigdet_i` may rise before edge 1. Reset then first reads 0 after edge Q+3.
- R10: In link up, let `lock_i` go low before edge 1. `link_valid_o` reads 0 after edge 2. `rx_digital_reset_o` reads 1 and `state_o` reads 2'b00 after edge 3.
- R11: In link up with gating on, a drop of `sigdet_i` has the same effect and timing as the lock loss in R10.
- R12: With `gate_en_i` = 0, `sigdet_i` has no effect. Qualification and link up proceed with it held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Raw CDR lock flag, asynchronous |
| sigdet_i | input | 1 | Raw signal-detect flag, asynchronous |
| gate_en_i | input | 1 | 1 selects waiting for signal detect before lock is considered |
| qual_cycles_i | input | CNT_W | Qualification length in clock cycles |
| rx_digital_reset_o | output | 1 | Receive digital reset, active high |
| link_valid_o | output | 1 | Received data may be used |
| state_o | output | 2 | Current phase, encoded as in R2 |

## Verification
Two events can land in the same cycle: the edge that completes qualification, and the edge on which synchronized lock falls. The bench provokes this by applying lock pulses exactly Q and Q-1 cycles long across a sweep of small Q values. The Q-cycle pulse must release reset for exactly one cycle with link-valid never raised. The Q-1 pulse must never release reset. A second overlap is loss of link in the same cycle that link-valid would rise. It is judged by the invariant that link-valid is never high while reset is asserted.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'b00,
    ST_WAIT = 2'b01,
    ST_QUAL = 2'b10,
    ST_UP   = 2'b11
  } rxq_state_e;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chain_q[STAGES-2]) == chain_q[STAGES-1]) else $error("sync"); // R3
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] qual_cycles_i,
  output logic             done_o
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    qual_eff, cnt_inc;

  assign qual_eff = (qual_cycles_i == '0) ? EW'(1) : {1'b0, qual_cycles_i};
  assign cnt_inc  = {1'b0, cnt_q} + EW'(1);
  assign done_o   = run_i && (cnt_inc >= qual_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_inc[CNT_W-1:0];
  end

  // a gap in run clears the count
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0) else $error("restart"); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> cnt_q != '0) else $error("overflow"); // R4
endmodule

// File: rtl/rxq_fsm.sv
module rxq_fsm
  import rxq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_s_i,
  input  logic       sigdet_s_i,
  input  logic       gate_en_i,
  input  logic       qual_done_i,
  output logic       qual_run_o,
  output logic       rx_reset_o,
  output logic       link_valid_o,
  output rxq_state_e state_o
);
  rxq_state_e state_q, state_d;
  logic       valid_q;
  logic       no_sig, drop;

  assign no_sig = gate_en_i && !sigdet_s_i;
  assign drop   = !lock_s_i || no_sig;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: state_d = no_sig ? ST_WAIT : ST_QUAL;
      ST_WAIT: if (!no_sig) state_d = ST_QUAL;
      ST_QUAL: begin
        if (no_sig)           state_d = ST_WAIT;
        else if (qual_done_i) state_d = ST_UP;
      end
      ST_UP:   if (drop) state_d = ST_HOLD;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_q == ST_UP) && !drop;
    end
  end

  assign qual_run_o   = (state_q == ST_QUAL) && !no_sig && lock_s_i;
  assign rx_reset_o   = (state_q != ST_UP);
  assign link_valid_o = valid_q && (state_q == ST_UP) && !drop;
  assign state_o      = state_q;

  AST_VALID_OUT_OF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> $past(state_q) == ST_UP) else $error("valid"); // R7
  AST_UP_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UP && $past(state_q) != ST_UP) |-> $past(lock_s_i)) else $error("up"); // R4
  AST_LOSS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UP && !lock_s_i) |=> state_q == ST_HOLD) else $error("loss"); // R10
  AST_GATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && gate_en_i && !sigdet_s_i) |=> state_q == ST_WAIT) else $error("gate"); // R8
endmodule

// File: rtl/rx_lock_qualifier.sv
module rx_lock_qualifier
  import rxq_pkg::*;
#(
  parameter int CNT_W       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             sigdet_i,
  input  logic             gate_en_i,
  input  logic [CNT_W-1:0] qual_cycles_i,
  output logic             rx_digital_reset_o,
  output logic             link_valid_o,
  output logic [1:0]       state_o
);
  logic [1:0] raw, synced;
  logic       run, done;
  rxq_state_e st;

  assign raw = {sigdet_i, lock_i};

  rxq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  rxq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .qual_cycles_i(qual_cycles_i),
    .done_o       (done)
  );

  rxq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_s_i    (synced[0]),
    .sigdet_s_i  (synced[1]),
    .gate_en_i   (gate_en_i),
    .qual_done_i (done),
    .qual_run_o  (run),
    .rx_reset_o  (rx_digital_reset_o),
    .link_valid_o(link_valid_o),
    .state_o     (st)
  );

  assign state_o = st;

  AST_NO_VALID_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_valid_o && rx_digital_reset_o)) else $error("valid in reset"); // R7
endmodule

// File: tb/rx_lock_qualifier_tb.sv
module rx_lock_qualifier_tb_top;
  localparam int CNT_W = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lock_i = 1'b0, sigdet_i = 1'b0, gate_en_i = 1'b0;
  logic [CNT_W-1:0] qual_cycles_i = '0;
  logic rx_digital_reset_o, link_valid_o;
  logic [1:0] state_o;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  rx_lock_qualifier #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .sigdet_i(sigdet_i),
    .gate_en_i(gate_en_i), .qual_cycles_i(qual_cycles_i),
    .rx_digital_reset_o(rx_digital_reset_o), .link_valid_o(link_valid_o),
    .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 valid while reset", int'(link_valid_o && rx_digital_reset_o), 0);
    end
  endtask

  task automatic do_reset(input bit gate);
    @(negedge clk);
    rst_ni = 1'b0; lock_i = 1'b0; sigdet_i = 1'b0; gate_en_i = gate;
    #1;
    chk("R1 reset out", int'(rx_digital_reset_o), 1);
    chk("R1 valid", int'(link_valid_o), 0);
    chk("R1 state", int'(state_o), 0);
    tick(2);
    rst_ni = 1'b1;
    chk("R1 after release", int'(rx_digital_reset_o), 1);
  endtask

  // edges until reset first low / valid first high
  task automatic measure(output int n_rst, output int n_val);
    n_rst = 0; n_val = 0;
    for (int n = 1; n <= 60; n++) begin
      tick(1);
      if (n_rst == 0 && !rx_digital_reset_o) n_rst = n;
      if (n_val == 0 && link_valid_o) n_val = n;
      if (n_rst != 0 && n_val != 0) break;
    end
  endtask

  task automatic measure_loss(input string tag);
    int n_val = 0, n_rst = 0;
    for (int n = 1; n <= 10; n++) begin
      tick(1);
      if (n_val == 0 && !link_valid_o) n_val = n;
      if (n_rst == 0 && rx_digital_reset_o) begin
        n_rst = n;
        chk({tag, " state hold"}, int'(state_o), 0);
      end
    end
    chk({tag, " valid drop"}, n_val, 2);
    chk({tag, " reset rise"}, n_rst, 3);
  endtask

  initial begin
    int nr, nv, qe, lows, highs;
    for (int q = 0; q <= 8; q++) begin
      qe = (q == 0) ? 1 : q;
      qual_cycles_i = CNT_W'(q);
      // R4, R7, R10, R12: gating off, sigdet held 0
      do_reset(1'b0);
      tick(3);
      chk("R2 qualify code", int'(state_o), 2);
      lock_i = 1'b1;
      measure(nr, nv);
      chk("R4 release edges", nr, qe + 2);
      chk("R7 valid edges", nv, qe + 3);
      chk("R2 up code", int'(state_o), 3);
      chk("R12 sigdet ignored", int'(link_valid_o), 1);
      lock_i = 1'b0;
      measure_loss("R10");
      // R5: short pulse, one low cycle, then hold
      tick(3);
      lock_i = 1'b1;
      tick(qe - 1);
      lock_i = 1'b0;
      tick(1);
      chk("R5 no early release", int'(rx_digital_reset_o), 1);
      lock_i = 1'b1;
      measure(nr, nv);
      chk("R5 restart edges", nr, qe + 2);
      lock_i = 1'b0;
      tick(6);
      // R6: pulse of Q-1 then exactly Q
      lows = 0; highs = 0;
      lock_i = 1'b1;
      for (int i = 0; i < qe - 1; i++) begin
        tick(1);
        if (!rx_digital_reset_o) lows++;
      end
      lock_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
        tick(1);
        if (!rx_digital_reset_o) lows++;
      end
      chk("R6 short pulse", lows, 0);
      lows = 0;
      lock_i = 1'b1;
      for (int i = 0; i < qe; i++) begin
        tick(1);
        if (!rx_digital_reset_o) lows++;
        if (link_valid_o) highs++;
      end
      lock_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
        tick(1);
        if (!rx_digital_reset_o) lows++;
        if (link_valid_o) highs++;
      end
      chk("R6 exact pulse release", lows, 1);
      chk("R6 exact pulse valid", highs, 0);
      // R8, R9, R11, R3: gating on
      do_reset(1'b1);
      lock_i = 1'b1;
      for (int i = 0; i < 12; i++) begin
        tick(1);
        if (i >= 2) chk("R8 wait state", int'(state_o), 1);
      end
      chk("R8 reset held", int'(rx_digital_reset_o), 1);
      sigdet_i = 1'b1;
      tick(2);
      chk("R3 sigdet not yet seen", int'(state_o), 1);
      measure(nr, nv);
      chk("R9 release edges", nr + 2, qe + 3);
      chk("R9 valid edges", nv + 2, qe + 4);
      sigdet_i = 1'b0;
      measure_loss("R11");
    end
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule